// File: doc/BRIEF.md
# Keyed Watchdog Timer with Selectable Reset

This block is a memory-mapped watchdog. Software programs a reload value and arms the counter by writing a fixed key to a restart word. While enabled, the counter steps down once per 1 MHz tick pulse supplied from outside. When an enabled tick finds the counter already at zero, the block records a timeout and, if resets are armed, sends a reset request of a chosen kind for a programmable number of ticks.

Three reset kinds are available: whole system-on-chip (with a per-peripheral selection vector), whole chip, or processor only. On an armed timeout the block clears its own enable bit. Software that waits for a reset can poll that bit and see it drop. A plain enable toggle does not reload the counter, so counting picks up where it stopped.

Register word index (the `addr` port): 0 count (read-only), 1 reload, 2 restart key, 3 control, 4 timeout flag, 5 timeout clear, 6 reset width, 7 peripheral reset selection. Words 2 and 5 read as zero.

Top module: `wdg_keyed`

## Requirements
- R1: Word 0 reads the live count and ignores writes. Word 1 holds a 32-bit reload value. Word 7 keeps only its low 26 bits. Words 2 and 5 read as 0. Read data follows `addr` combinationally.
- R2: A write of exactly 0x0000_4755 to word 2 copies the reload value into the counter at that clock edge. Any other value written there changes nothing. A key write wins over a tick in the same cycle.
- R3: On a tick with control bit 0 (enable) set and a nonzero count, the count drops by one. With enable clear, the count holds.
- R4: A tick with enable set and the count at zero (and no key write in that cycle) is a timeout: word 4 bit 0 becomes 1 and the count stays 0.
- R5: On a timeout with control bit 1 (reset arm) set, the enable bit is cleared and a reset pulse starts. Without reset arm, enable stays set and no reset output moves.
- R6: A write to word 5 with bit 0 set clears the timeout flag. Other values have no effect. A timeout in the same cycle keeps the flag set.
- R7: Control bit 4 always reads 1 and ignores writes. Bit 7 is plain read/write storage with no effect.
- R8: Control bits 6:5 are captured at timeout and select the output: 0 drives `rst_soc_o`, 1 drives `rst_chip_o`, 2 drives `rst_cpu_o`, 3 drives none. At most one of the three is high.
- R9: `rst_mask_o` carries the selection vector captured at timeout, only while a system-on-chip reset is active. Otherwise it is zero.
- R10: The reset output rises the cycle after the timeout edge and stays high until the Nth following tick, where N is word 6 (8 bits) and 0 counts as 1.
- R11: Setting enable again without a key write resumes counting from the held count.
- R12: After reset the count, reload, width, selection and timeout flag are 0, enable and reset arm are clear, control reads 0x10, and all reset outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle 1 MHz tick pulse |
| we | input | 1 | Write strobe |
| addr | input | 3 | Register word index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| rst_soc_o | output | 1 | System-on-chip reset request |
| rst_chip_o | output | 1 | Whole-chip reset request |
| rst_cpu_o | output | 1 | Processor-only reset request |
| rst_mask_o | output | 26 | Per-peripheral reset selection |

## Verification
Register writes, key loads, tick decrements and the timeout flag all take effect at the clock edge that samples them. They show on `rdata` the same cycle after that edge, since read data is combinational from `addr`. The reset outputs rise one edge after the timeout tick and fall at the edge of the Nth later tick. With ticks every five cycles, a pulse therefore lasts exactly five times N cycles. The bench drives inputs on the falling edge, advances a behavioural model on the rising edge, and compares every output 2 ns after each rising edge. Directed reads and pulse-length counts use that same sampling point.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [31:0] KICK_KEY = 32'h0000_4755;

  typedef enum logic [ADDR_W-1:0] {
    IDX_COUNT  = 3'd0,
    IDX_RELOAD = 3'd1,
    IDX_KICK   = 3'd2,
    IDX_CTRL   = 3'd3,
    IDX_TOSTAT = 3'd4,
    IDX_TOCLR  = 3'd5,
    IDX_WIDTH  = 3'd6,
    IDX_SEL    = 3'd7
  } reg_idx_e;

  typedef enum logic [1:0] {
    MODE_SOC  = 2'd0,
    MODE_CHIP = 2'd1,
    MODE_CPU  = 2'd2,
    MODE_NONE = 2'd3
  } rst_mode_e;
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned MASK_W = 26,
  parameter int unsigned PW_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic              expire_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              kick_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              en_o,
  output logic              rsten_o,
  output rst_mode_e         mode_o,
  output logic [PW_W-1:0]   width_o,
  output logic [MASK_W-1:0] sel_o,
  output logic              to_o,
  output logic [DW-1:0]     rdata
);
  logic [CNT_W-1:0]  reload_q, reload_d;
  logic              en_q, en_d, rsten_q, rsten_d, boot_q, boot_d, to_q, to_d;
  rst_mode_e         mode_q, mode_d;
  logic [PW_W-1:0]   width_q, width_d;
  logic [MASK_W-1:0] sel_q, sel_d;
  logic              wr_reload, wr_ctrl, wr_clr, wr_width, wr_sel;

  assign wr_reload = we && (addr == IDX_RELOAD);
  assign wr_ctrl   = we && (addr == IDX_CTRL);
  assign wr_clr    = we && (addr == IDX_TOCLR) && wdata[0];
  assign wr_width  = we && (addr == IDX_WIDTH);
  assign wr_sel    = we && (addr == IDX_SEL);
  assign kick_o    = we && (addr == IDX_KICK) && (wdata == KICK_KEY);

  always_comb begin
    reload_d = wr_reload ? wdata[CNT_W-1:0] : reload_q;
    width_d  = wr_width ? wdata[PW_W-1:0] : width_q;
    sel_d    = wr_sel ? wdata[MASK_W-1:0] : sel_q;
    en_d     = en_q;
    rsten_d  = rsten_q;
    boot_d   = boot_q;
    mode_d   = mode_q;
    if (wr_ctrl) begin
      en_d    = wdata[0];
      rsten_d = wdata[1];
      mode_d  = rst_mode_e'(wdata[6:5]);
      boot_d  = wdata[7];
    end
    if (expire_i && rsten_q) en_d = 1'b0;
    to_d = to_q;
    if (wr_clr) to_d = 1'b0;
    if (expire_i) to_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      en_q     <= 1'b0;
      rsten_q  <= 1'b0;
      boot_q   <= 1'b0;
      mode_q   <= MODE_SOC;
      width_q  <= '0;
      sel_q    <= '0;
      to_q     <= 1'b0;
    end else begin
      reload_q <= reload_d;
      en_q     <= en_d;
      rsten_q  <= rsten_d;
      boot_q   <= boot_d;
      mode_q   <= mode_d;
      width_q  <= width_d;
      sel_q    <= sel_d;
      to_q     <= to_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (reg_idx_e'(addr))
      IDX_COUNT:  rdata[CNT_W-1:0] = cnt_i;
      IDX_RELOAD: rdata[CNT_W-1:0] = reload_q;
      IDX_CTRL:   rdata[7:0] = {boot_q, mode_q, 1'b1, 2'b00, rsten_q, en_q};
      IDX_TOSTAT: rdata[0] = to_q;
      IDX_WIDTH:  rdata[PW_W-1:0] = width_q;
      IDX_SEL:    rdata[MASK_W-1:0] = sel_q;
      default:    rdata = '0;
    endcase
  end

  assign reload_o = reload_q;
  assign en_o     = en_q;
  assign rsten_o  = rsten_q;
  assign mode_o   = mode_q;
  assign width_o  = width_q;
  assign sel_o    = sel_q;
  assign to_o     = to_q;
endmodule

// File: rtl/wdg_count.sv
module wdg_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             kick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step;

  assign step     = en_i && tick_i && !kick_i;
  assign expire_o = step && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (kick_i)                     cnt_d = reload_i;
    else if (step && cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse
  import wdg_pkg::*;
#(
  parameter int unsigned MASK_W = 26,
  parameter int unsigned PW_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              start_i,
  input  rst_mode_e         mode_i,
  input  logic [PW_W-1:0]   width_i,
  input  logic [MASK_W-1:0] sel_i,
  output logic              rst_soc_o,
  output logic              rst_chip_o,
  output logic              rst_cpu_o,
  output logic [MASK_W-1:0] rst_mask_o
);
  localparam logic [PW_W-1:0] ONE = {{(PW_W-1){1'b0}}, 1'b1};

  logic              act_q, act_d;
  logic [PW_W-1:0]   left_q, left_d;
  rst_mode_e         lmode_q, lmode_d;
  logic [MASK_W-1:0] lsel_q, lsel_d;

  always_comb begin
    act_d   = act_q;
    left_d  = left_q;
    lmode_d = lmode_q;
    lsel_d  = lsel_q;
    if (start_i) begin
      act_d   = 1'b1;
      left_d  = (width_i == '0) ? ONE : width_i;
      lmode_d = mode_i;
      lsel_d  = sel_i;
    end else if (act_q && tick_i) begin
      if (left_q == ONE) act_d = 1'b0;
      else               left_d = left_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      left_q  <= '0;
      lmode_q <= MODE_SOC;
      lsel_q  <= '0;
    end else begin
      act_q   <= act_d;
      left_q  <= left_d;
      lmode_q <= lmode_d;
      lsel_q  <= lsel_d;
    end
  end

  assign rst_soc_o  = act_q && (lmode_q == MODE_SOC);
  assign rst_chip_o = act_q && (lmode_q == MODE_CHIP);
  assign rst_cpu_o  = act_q && (lmode_q == MODE_CPU);
  assign rst_mask_o = rst_soc_o ? lsel_q : '0;
endmodule

// File: rtl/wdg_keyed.sv
module wdg_keyed
  import wdg_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned MASK_W = 26,
  parameter int unsigned PW_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              rst_soc_o,
  output logic              rst_chip_o,
  output logic              rst_cpu_o,
  output logic [MASK_W-1:0] rst_mask_o
);
  logic              kick_w, en_w, rsten_w, expire_w, to_w;
  logic [CNT_W-1:0]  reload_w, cnt_w;
  rst_mode_e         mode_w;
  logic [PW_W-1:0]   width_w;
  logic [MASK_W-1:0] sel_w;

  wdg_regs #(.DW(DW), .CNT_W(CNT_W), .MASK_W(MASK_W), .PW_W(PW_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
    .expire_i(expire_w), .cnt_i(cnt_w), .kick_o(kick_w), .reload_o(reload_w),
    .en_o(en_w), .rsten_o(rsten_w), .mode_o(mode_w), .width_o(width_w),
    .sel_o(sel_w), .to_o(to_w), .rdata(rdata)
  );

  wdg_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .en_i(en_w), .tick_i(tick_i), .kick_i(kick_w),
    .reload_i(reload_w), .cnt_o(cnt_w), .expire_o(expire_w)
  );

  wdg_pulse #(.MASK_W(MASK_W), .PW_W(PW_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .start_i(expire_w && rsten_w),
    .mode_i(mode_w), .width_i(width_w), .sel_i(sel_w),
    .rst_soc_o(rst_soc_o), .rst_chip_o(rst_chip_o), .rst_cpu_o(rst_cpu_o),
    .rst_mask_o(rst_mask_o)
  );
endmodule

// File: rtl/wdg_keyed_chk.sv
module wdg_keyed_chk #(
  parameter int unsigned DW     = 32,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned MASK_W = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              we,
  input logic [2:0]        addr,
  input logic [DW-1:0]     wdata,
  input logic [DW-1:0]     rdata,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  reload,
  input logic              en,
  input logic              rsten,
  input logic              to,
  input logic              rst_soc_o,
  input logic              rst_chip_o,
  input logic              rst_cpu_o,
  input logic [MASK_W-1:0] rst_mask_o
);
  logic key_wr;
  assign key_wr = we && (addr == 3'd2) && (wdata == 32'h0000_4755);

  p_key_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr |=> (cnt == $past(reload)));

  p_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !key_wr) |=> $stable(cnt));

  p_expire_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick_i && cnt == '0 && !key_wr) |=> to);

  p_expire_drop_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rsten && tick_i && cnt == '0 && !key_wr && !(we && addr == 3'd3)) |=> !en);

  p_bit4_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 3'd3) |-> rdata[4]);

  p_one_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_soc_o, rst_chip_o, rst_cpu_o}));

  p_mask_soc_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_mask_o != '0) |-> rst_soc_o);
endmodule

bind wdg_keyed wdg_keyed_chk #(.DW(DW), .CNT_W(CNT_W), .MASK_W(MASK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .we(we), .addr(addr),
  .wdata(wdata), .rdata(rdata), .cnt(cnt_w), .reload(reload_w), .en(en_w),
  .rsten(rsten_w), .to(to_w), .rst_soc_o(rst_soc_o), .rst_chip_o(rst_chip_o),
  .rst_cpu_o(rst_cpu_o), .rst_mask_o(rst_mask_o)
);

// File: tb/tb_wdg_keyed.sv
`timescale 1ns/1ps
module tb_wdg_keyed;
  localparam int TDIV = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_soc_o, rst_chip_o, rst_cpu_o;
  logic [25:0] rst_mask_o;

  wdg_keyed dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rst_soc_o(rst_soc_o),
    .rst_chip_o(rst_chip_o), .rst_cpu_o(rst_cpu_o), .rst_mask_o(rst_mask_o)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, tphase = 0;
  bit done = 0;
  int hc_soc = 0, hc_chip = 0, hc_cpu = 0;
  logic [25:0] mask_seen = '0;

  // behavioural reference
  logic [31:0] m_cnt, m_reload;
  bit m_en, m_rsten, m_boot, m_to, m_act;
  int m_mode, m_lmode, m_width, m_left;
  logic [25:0] m_sel, m_lsel;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_reload = 0; m_en = 0; m_rsten = 0; m_boot = 0; m_to = 0;
      m_act = 0; m_mode = 0; m_lmode = 0; m_width = 0; m_left = 0;
      m_sel = 0; m_lsel = 0;
    end else begin
      bit kick, expire, start;
      kick   = we && addr == 3'd2 && wdata == 32'h4755;
      expire = m_en && tick_i && m_cnt == 0 && !kick;
      start  = expire && m_rsten;
      if (start) begin
        m_act = 1; m_left = (m_width == 0) ? 1 : m_width;
        m_lmode = m_mode; m_lsel = m_sel;
      end else if (m_act && tick_i) begin
        if (m_left == 1) m_act = 0; else m_left--;
      end
      if (kick) m_cnt = m_reload;
      else if (m_en && tick_i && m_cnt != 0) m_cnt--;
      if (we && addr == 3'd3) begin
        m_en = wdata[0]; m_rsten = wdata[1]; m_mode = wdata[6:5]; m_boot = wdata[7];
      end
      if (start) m_en = 0;
      if (we && addr == 3'd5 && wdata[0]) m_to = 0;
      if (expire) m_to = 1;
      if (we && addr == 3'd1) m_reload = wdata;
      if (we && addr == 3'd6) m_width = wdata[7:0];
      if (we && addr == 3'd7) m_sel = wdata[25:0];
    end
  end

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_cnt;
      3'd1: return m_reload;
      3'd3: return {24'd0, m_boot, 2'(m_mode), 1'b1, 2'b00, m_rsten, m_en};
      3'd4: return {31'd0, m_to};
      3'd6: return 32'(m_width);
      3'd7: return {6'd0, m_sel};
      default: return 32'd0;
    endcase
  endfunction

  // per-cycle comparison, 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk("R1 rdata", rdata, exp_rd(addr));
      chk("R8 soc", {31'd0, rst_soc_o}, {31'd0, m_act && m_lmode == 0});
      chk("R8 chip", {31'd0, rst_chip_o}, {31'd0, m_act && m_lmode == 1});
      chk("R8 cpu", {31'd0, rst_cpu_o}, {31'd0, m_act && m_lmode == 2});
      chk("R9 mask", {6'd0, rst_mask_o}, (m_act && m_lmode == 0) ? {6'd0, m_lsel} : 32'd0);
      if (rst_soc_o) hc_soc++;
      if (rst_chip_o) hc_chip++;
      if (rst_cpu_o) hc_cpu++;
      mask_seen |= rst_mask_o;
    end
  end

  always @(negedge clk) begin
    tphase = (tphase + 1) % TDIV;
    tick_i = (tphase == 0);
  end

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1; fails++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); we = 0; addr = a;
    @(posedge clk); #2; v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_hc();
    @(negedge clk); hc_soc = 0; hc_chip = 0; hc_cpu = 0; mask_seen = '0;
  endtask

  initial begin
    logic [31:0] v, v1;
    idle(3);
    @(negedge clk); rst_n = 1;
    rd(3'd3, v); chk("R12 ctrl after reset", v, 32'h10);
    rd(3'd0, v); chk("R12 count after reset", v, 0);
    rd(3'd4, v); chk("R12 flag after reset", v, 0);
    chk("R12 outputs low", {rst_soc_o, rst_chip_o, rst_cpu_o}, 0);

    wr(3'd1, 32'd5);
    wr(3'd2, 32'h1234);
    rd(3'd0, v); chk("R2 wrong key ignored", v, 0);
    wr(3'd2, 32'h0001_4755);
    rd(3'd0, v); chk("R2 key upper bits ignored", v, 0);
    wr(3'd2, 32'h4755);
    rd(3'd0, v); chk("R2 key loads reload", v, 5);
    wr(3'd0, 32'h99);
    rd(3'd0, v); chk("R1 count read-only", v, 5);
    rd(3'd2, v); chk("R1 restart reads zero", v, 0);

    wr(3'd3, 32'h0);
    rd(3'd3, v); chk("R7 bit4 ignores write", v, 32'h10);
    wr(3'd3, 32'h80);
    rd(3'd3, v); chk("R7 bit7 storage", v, 32'h90);
    idle(20);
    rd(3'd0, v); chk("R3 hold while disabled", v, 5);

    wr(3'd3, 32'h01);
    idle(45);
    rd(3'd4, v); chk("R4 timeout flag", v, 1);
    rd(3'd0, v); chk("R4 count stays zero", v, 0);
    rd(3'd3, v); chk("R5 enable kept without arm", v, 32'h11);
    chk("R5 no reset without arm", {rst_soc_o, rst_chip_o, rst_cpu_o}, 0);
    wr(3'd3, 32'h0);
    wr(3'd5, 32'h2);
    rd(3'd4, v); chk("R6 clear needs bit0", v, 1);
    wr(3'd5, 32'h1);
    rd(3'd4, v); chk("R6 clear", v, 0);

    wr(3'd1, 32'd20); wr(3'd2, 32'h4755);
    wr(3'd3, 32'h01); idle(30);
    wr(3'd3, 32'h00);
    rd(3'd0, v1); idle(30);
    rd(3'd0, v); chk("R3 held after disable", v, v1);
    wr(3'd3, 32'h01); idle(12);
    rd(3'd0, v); chk("R11 resumes below held value", {31'd0, (v < v1) && (v + 4 >= v1)}, 1);
    wr(3'd3, 32'h00);

    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd7, v); chk("R1 selection width", v, 32'h03FF_FFFF);
    wr(3'd6, 32'd3); wr(3'd1, 32'd2); wr(3'd2, 32'h4755);
    clr_hc();
    wr(3'd3, 32'h43); idle(70);
    chk("R10 cpu pulse length", hc_cpu, 3 * TDIV);
    chk("R8 only cpu", hc_soc + hc_chip, 0);
    chk("R9 no mask in cpu mode", {6'd0, mask_seen}, 0);
    rd(3'd3, v); chk("R5 enable dropped", v, 32'h52);

    wr(3'd6, 32'd0); wr(3'd2, 32'h4755);
    clr_hc();
    wr(3'd3, 32'h23); idle(60);
    chk("R10 width zero acts as one", hc_chip, TDIV);
    chk("R8 only chip", hc_soc + hc_cpu, 0);

    wr(3'd7, 32'h0300_0005); wr(3'd6, 32'd2); wr(3'd2, 32'h4755);
    clr_hc();
    wr(3'd3, 32'h03); idle(60);
    chk("R8 soc pulse", hc_soc, 2 * TDIV);
    chk("R9 captured selection", {6'd0, mask_seen}, 32'h0300_0005);

    wr(3'd2, 32'h4755);
    clr_hc();
    wr(3'd3, 32'h63); idle(60);
    chk("R8 mode 3 drives nothing", hc_soc + hc_chip + hc_cpu, 0);
    rd(3'd4, v); chk("R4 flag in mode 3", v, 1);

    idle(5);
    done = 1;
    report();
  end
endmodule